// File: doc/BRIEF.md
# Interleaved Line Pixel Sequencer

This block sits behind the converter of one colour output of a two-line linear image sensor. The pixels of that output reach it as one stream in which the two lines alternate: a main-line pixel, then the sub-line pixel at the same position, and so on for the whole readout. The block numbers every position, decides whether it is a dummy, an optical-black or an effective pixel, and keeps a separate black reference for each of the two lines. It then emits only the effective pixels, each one corrected by the black level of its own line.

A readout starts with a sample that comes with the start marker. Per line, the positions are laid out in this order: leading dummies, a window of optical-black pixels, a further dummy, the effective pixels and four trailing dummies. The black level is the sum of the line's black pixels shifted right by the log2 of their count. The black window ends before the first effective pixel, so every effective pixel is corrected with the black level of its own readout. A start marker that arrives before a readout is complete restarts the count and raises a framing flag that stays set. One instance is used per colour output.

Top module: `ccdPixSeq`

## Requirements
- R1: While reset is held and right after it is released, `outValid` and `framingErr` are 0.
- R2: The sample that carries `lineStart` is main-line position 1. After that the samples alternate main then sub at each position, and `outSub` reports the line of each emitted pixel (0 for main, 1 for sub).
- R3: Only positions EFF_FIRST to EFF_FIRST+EFF_COUNT-1 produce output. The leading dummies, the black window, the dummy just before the effective region and the TAIL_DUMMY trailing positions never raise `outValid`.
- R4: `outIdx` of an effective pixel at position p is p-EFF_FIRST+1, so the first effective pixel has index 1.
- R5: Each line's black level is the sum of that line's 2^BLACK_LOG2 samples at positions BLACK_FIRST onward, shifted right by BLACK_LOG2. Main and sub lines each use only their own samples.
- R6: `outPix` is the raw value minus the line's black level, and it saturates at 0 when the raw value is not above the black level.
- R7: An accepted effective sample gives `outValid` high for exactly one cycle, in the clock cycle after the edge that takes the sample. Cycles without `sampleStb` emit nothing.
- R8: Once the last sub-line sample of a readout has been taken, samples without `lineStart` are ignored until the next `lineStart`.
- R9: A `lineStart` during an unfinished readout restarts numbering at main position 1. It also sets `framingErr`, which stays set until reset.
- R10: The black sums are cleared at every `lineStart`, so each readout is corrected with its own black window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | A pixel word is present on pixIn |
| lineStart | input | 1 | Marks the first sample (main position 1) of a readout |
| pixIn | input | DATA_W | Digitized pixel value |
| outValid | output | 1 | Corrected effective pixel present |
| outSub | output | 1 | Line of the emitted pixel: 0 main, 1 sub |
| outIdx | output | IDX_W | 1-based effective-pixel index |
| outPix | output | DATA_W | Black-corrected pixel value |
| framingErr | output | 1 | Sticky flag: a readout was restarted early |

## Verification
A reduced line map is swept completely: every position of every readout, on both lines. Each emitted word is compared with an arithmetic model, and every non-effective position is checked for silence. The readouts differ in black level: a low level makes the subtraction visible, a high level drives most pixels into the zero clamp, and main and sub black values are offset so that a mix-up between the two lines shows. Idle gaps, stray samples after a finished readout and an early restart in the middle of the effective region separate the correct handling of the strobe, the idle state and the framing flag from a counter that simply runs on.

// File: rtl/ccdSeqPkg.sv
package ccdSeqPkg;
  typedef struct packed {
    logic clrAcc;   // new readout: clear both black sums
    logic accEn;    // current sample belongs to the black window
    logic emitEn;   // current sample is an effective pixel
    logic lineSub;  // current sample belongs to the sub line
  } seqStb_t;
endpackage

// File: rtl/ccdSeqCtrl.sv
module ccdSeqCtrl
  import ccdSeqPkg::*;
#(
  parameter int LINE_POS    = 5394,
  parameter int POS_W       = 13,
  parameter int BLACK_FIRST = 24,
  parameter int BLACK_COUNT = 16,
  parameter int EFF_FIRST   = 41,
  parameter int EFF_COUNT   = 5350,
  parameter int IDX_W       = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleStb,
  input  logic             lineStart,
  output seqStb_t          stb,
  output logic [IDX_W-1:0] effIdx,
  output logic             framingErr
);
  localparam logic [POS_W-1:0] ONE_POS  = POS_W'(1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(LINE_POS);
  localparam logic [POS_W-1:0] BLK_LO   = POS_W'(BLACK_FIRST);
  localparam logic [POS_W-1:0] BLK_HI   = POS_W'(BLACK_FIRST + BLACK_COUNT - 1);
  localparam logic [POS_W-1:0] EFF_LO   = POS_W'(EFF_FIRST);
  localparam logic [POS_W-1:0] EFF_HI   = POS_W'(EFF_FIRST + EFF_COUNT - 1);

  logic [POS_W-1:0] posCnt, curPos;
  logic subNext, curSub, inLine, take, inBlack, inEff;

  always_comb begin
    curPos  = lineStart ? ONE_POS : posCnt;
    curSub  = lineStart ? 1'b0 : subNext;
    take    = sampleStb && (lineStart || inLine);
    inBlack = (curPos >= BLK_LO) && (curPos <= BLK_HI);
    inEff   = (curPos >= EFF_LO) && (curPos <= EFF_HI);
    stb.clrAcc  = take && lineStart;
    stb.accEn   = take && inBlack;
    stb.emitEn  = take && inEff;
    stb.lineSub = curSub;
    effIdx = IDX_W'(curPos - EFF_LO + ONE_POS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posCnt     <= ONE_POS;
      subNext    <= 1'b0;
      inLine     <= 1'b0;
      framingErr <= 1'b0;
    end else begin
      if (sampleStb && lineStart && inLine) framingErr <= 1'b1;
      if (take) begin
        if (curSub) begin
          subNext <= 1'b0;
          if (curPos == LAST_POS) begin
            inLine <= 1'b0;
            posCnt <= ONE_POS;
          end else begin
            posCnt <= curPos + ONE_POS;
          end
        end else begin
          subNext <= 1'b1;
          posCnt  <= curPos;
          inLine  <= 1'b1;
        end
      end
    end
  end

  // R2
  sub_follows_main_chk: assert property (@(posedge clk) disable iff (!rstN)
    (take && !curSub) |=> subNext);
  // R3
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (posCnt != '0) && (posCnt <= LAST_POS));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    framingErr |=> framingErr);
endmodule

// File: rtl/ccdSeqDatapath.sv
module ccdSeqDatapath
  import ccdSeqPkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int BLACK_LOG2 = 4,
  parameter int IDX_W      = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStb_t           stb,
  input  logic [IDX_W-1:0]  effIdx,
  input  logic [DATA_W-1:0] pixIn,
  output logic              outValid,
  output logic              outSub,
  output logic [IDX_W-1:0]  outIdx,
  output logic [DATA_W-1:0] outPix
);
  localparam int ACC_W = DATA_W + BLACK_LOG2;

  logic [ACC_W-1:0]  accMain, accSub, accSel;
  logic [DATA_W-1:0] blackLvl, corrected;

  always_comb begin
    accSel    = stb.lineSub ? accSub : accMain;
    blackLvl  = DATA_W'(accSel >> BLACK_LOG2);
    corrected = (pixIn > blackLvl) ? (pixIn - blackLvl) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accMain <= '0;
      accSub  <= '0;
    end else if (stb.clrAcc) begin
      accMain <= '0;
      accSub  <= '0;
    end else if (stb.accEn) begin
      if (stb.lineSub) accSub  <= accSub  + ACC_W'(pixIn);
      else             accMain <= accMain + ACC_W'(pixIn);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSub   <= 1'b0;
      outIdx   <= '0;
      outPix   <= '0;
    end else begin
      outValid <= stb.emitEn;
      if (stb.emitEn) begin
        outSub <= stb.lineSub;
        outIdx <= effIdx;
        outPix <= corrected;
      end
    end
  end

  // R3
  acc_emit_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.accEn && stb.emitEn));
  // R6
  sat_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.emitEn |=> (outPix <= $past(pixIn)));
  // R4
  idx_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outIdx != '0));
endmodule

// File: rtl/ccdPixSeq.sv
module ccdPixSeq
  import ccdSeqPkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int BLACK_FIRST = 24,
  parameter int BLACK_LOG2  = 4,
  parameter int EFF_FIRST   = 41,
  parameter int EFF_COUNT   = 5350,
  parameter int TAIL_DUMMY  = 4,
  parameter int IDX_W       = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleStb,
  input  logic              lineStart,
  input  logic [DATA_W-1:0] pixIn,
  output logic              outValid,
  output logic              outSub,
  output logic [IDX_W-1:0]  outIdx,
  output logic [DATA_W-1:0] outPix,
  output logic              framingErr
);
  localparam int BLACK_COUNT = 1 << BLACK_LOG2;
  localparam int LINE_POS    = EFF_FIRST + EFF_COUNT - 1 + TAIL_DUMMY;
  localparam int POS_W       = $clog2(LINE_POS + 1);

  seqStb_t          stb;
  logic [IDX_W-1:0] effIdx;

  ccdSeqCtrl #(
    .LINE_POS(LINE_POS), .POS_W(POS_W), .BLACK_FIRST(BLACK_FIRST),
    .BLACK_COUNT(BLACK_COUNT), .EFF_FIRST(EFF_FIRST), .EFF_COUNT(EFF_COUNT),
    .IDX_W(IDX_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .lineStart(lineStart),
    .stb(stb), .effIdx(effIdx), .framingErr(framingErr)
  );

  ccdSeqDatapath #(
    .DATA_W(DATA_W), .BLACK_LOG2(BLACK_LOG2), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .effIdx(effIdx), .pixIn(pixIn),
    .outValid(outValid), .outSub(outSub), .outIdx(outIdx), .outPix(outPix)
  );
endmodule

// File: tb/ccdPixSeq_tb_top.sv
module ccdPixSeq_tb_top;
  localparam int DW   = 12;
  localparam int BF   = 4;
  localparam int BL2  = 2;
  localparam int EF   = 9;
  localparam int EC   = 20;
  localparam int TD   = 4;
  localparam int IW   = 13;
  localparam int LPOS = EF + EC - 1 + TD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStb = 1'b0;
  logic lineStart = 1'b0;
  logic [DW-1:0] pixIn = '0;
  logic outValid, outSub, framingErr;
  logic [IW-1:0] outIdx;
  logic [DW-1:0] outPix;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ccdPixSeq #(
    .DATA_W(DW), .BLACK_FIRST(BF), .BLACK_LOG2(BL2), .EFF_FIRST(EF),
    .EFF_COUNT(EC), .TAIL_DUMMY(TD), .IDX_W(IW)
  ) dut_i (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .lineStart(lineStart),
    .pixIn(pixIn), .outValid(outValid), .outSub(outSub), .outIdx(outIdx),
    .outPix(outPix), .framingErr(framingErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doSample(input bit ls, input int data);
    sampleStb = 1'b1;
    lineStart = ls;
    pixIn     = DW'(data);
    @(posedge clk);
    #1;
    sampleStb = 1'b0;
    lineStart = 1'b0;
  endtask

  task automatic idleCycle();
    @(posedge clk);
    #1;
    chk(outValid == 1'b0, "R7 idle cycle", int'(outValid), 0);
  endtask

  // Drives positions 1..stopPos of one readout and checks each output.
  task automatic runLine(input int lineNo, input int stopPos, input int blkBase, input bit gaps);
    int blkSum[2];
    blkSum[0] = 0;
    blkSum[1] = 0;
    for (int pos = 1; pos <= stopPos; pos++) begin
      for (int s = 0; s < 2; s++) begin
        int data;
        bit isBlk, isEff;
        isBlk = (pos >= BF) && (pos < BF + (1 << BL2));
        isEff = (pos >= EF) && (pos < EF + EC);
        if (isBlk) data = blkBase + s * 400 + ((pos * 5 + s * 9 + lineNo * 3) % 17);
        else       data = (pos * 149 + s * 57 + lineNo * 311) % 4096;
        doSample(pos == 1 && s == 0, data);
        if (isBlk) blkSum[s] += data;
        if (isEff) begin
          int blk, expPix;
          blk = blkSum[s] >> BL2;
          expPix = (data > blk) ? data - blk : 0;
          chk(outValid == 1'b1, "R3 effective valid", int'(outValid), 1);
          chk(outSub == s[0], "R2 line select", int'(outSub), s);
          chk(int'(outIdx) == pos - EF + 1, "R4 index", int'(outIdx), pos - EF + 1);
          chk(int'(outPix) == expPix, (expPix == 0) ? "R6 clamp" : "R5 corrected",
              int'(outPix), expPix);
        end else begin
          chk(outValid == 1'b0, "R3 non-effective silent", int'(outValid), 0);
        end
        if (gaps && (pos % 5 == 0)) idleCycle();
      end
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(outValid == 1'b0, "R1 valid in reset", int'(outValid), 0);
    chk(framingErr == 1'b0, "R1 flag in reset", int'(framingErr), 0);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk(outValid == 1'b0, "R1 valid after reset", int'(outValid), 0);

    runLine(0, LPOS, 200, 1);
    chk(framingErr == 1'b0, "R9 no flag on clean line", int'(framingErr), 0);

    for (int k = 0; k < 3; k++) begin
      doSample(1'b0, 4000 - k);
      chk(outValid == 1'b0, "R8 stray sample ignored", int'(outValid), 0);
    end

    runLine(1, LPOS, 3000, 0);  // R10 new black, heavy R6 clamping
    runLine(2, 15, 100, 0);
    chk(framingErr == 1'b0, "R9 no flag before restart", int'(framingErr), 0);
    runLine(3, LPOS, 50, 1);
    chk(framingErr == 1'b1, "R9 flag after early start", int'(framingErr), 1);
    doSample(1'b0, 123);
    chk(outValid == 1'b0, "R8 ignored after line", int'(outValid), 0);
    runLine(4, LPOS, 1500, 0);
    chk(framingErr == 1'b1, "R9 flag sticky", int'(framingErr), 1);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule